// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives one network transmit queue whose work list is a ring of 16-byte descriptors in host memory. Software supplies the ring geometry and a completion mode as static inputs, raises the queue enable, and then moves the tail index forward whenever it has queued new work. While the head index trails the tail, the engine handles one descriptor at a time. It reads the descriptor and checks it. It then reads the packet buffer that the descriptor names and streams those bytes out as a single frame. Next it reports completion to host memory. Once that write is acknowledged, it moves the head forward and pulses an interrupt request.

There are two completion modes. In the first, the engine writes over the descriptor slot, clearing the buffer address and marking the slot as done. In the second, it leaves the descriptor alone and writes the new head index, 4 bytes long, to a separate host address.

Memory reads, memory writes and the frame output all use valid/ready handshakes. A request that is offered stays stable until it is accepted. The buffer read data passes straight through to the frame output, so a low `tx_ready` back-pressures the read response channel directly. The engine holds no frame buffer of its own.

Top module: `txring_engine`

## Requirements
- R1: After reset the head index is 0, `err` and `irq` are low, and no read request, write request or frame beat is offered.
- R2: A descriptor fetch starts only while the queue is enabled and the head index differs from the tail index. It is a 16-byte read at ring base + 16 × head. A tail write is accepted at any time, including while the queue is disabled.
- R3: The first 8-byte response beat of a descriptor is the buffer address. The second beat is the control word, with the type in bits [3:0], the end-of-packet flag in bit 4 and the buffer size in bytes in bits [47:34]. The other bits are ignored. For a valid descriptor, the engine then reads exactly the buffer size in bytes from the buffer address.
- R4: A descriptor is unsupported if its type is not 0 (data), its end-of-packet flag is clear, or its size is 0. An unsupported descriptor sets `err` and produces no frame, no completion write and no head movement. No further fetch happens until the next rising edge of the enable.
- R5: The frame carries the buffer bytes in address order, eight per beat, with the lowest address in `tx_data[7:0]`. `tx_keep` is low-aligned and is all ones on every beat except the last. `tx_last` marks the final beat.
- R6: A frame beat is held with `tx_valid` high until `tx_ready` is high. No byte is lost or repeated under back-pressure. At most one of the read request, the write request and the frame output is valid in any cycle.
- R7: With head writeback off, the completion is a 16-byte write to the descriptor's own address. `wr_data[63:0]` is 0 (the cleared address) and `wr_data[127:64]` is 0xF (the done type).
- R8: With head writeback on, the completion is a 4-byte write to the writeback address, with `wr_data[31:0]` = (index + 1) mod ring length.
- R9: The head becomes (index + 1) mod ring length only after `wr_ack` for the completion write. In the same cycle that the new head appears, `irq` is high for exactly one cycle.
- R10: If the queue is disabled when the completion is acknowledged, the head does not move and no `irq` is raised.
- R11: The ring length, ring base, writeback mode and writeback address are captured on the rising edge of the enable. Changes to them while the queue is enabled have no effect. The same edge resets the head to 0 and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Queue enable |
| cfg_ring_base | input | ADDR_W | Host address of ring slot 0 |
| cfg_ring_len | input | IDX_W+1 | Number of ring slots |
| cfg_hwb_en | input | 1 | Select head-index writeback completion |
| cfg_hwb_addr | input | ADDR_W | Host address for head-index writeback |
| tail_we | input | 1 | Tail index write strobe |
| tail_wdata | input | IDX_W | New tail index |
| head_idx | output | IDX_W | Current head index |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read start address |
| rd_req_len | output | 16 | Read length in bytes |
| rd_rsp_valid | input | 1 | Read data beat present |
| rd_rsp_ready | output | 1 | Read data beat taken |
| rd_rsp_data | input | 64 | Read data, lowest address in bits [7:0] |
| wr_valid | output | 1 | Completion write offered |
| wr_ready | input | 1 | Completion write accepted |
| wr_addr | output | ADDR_W | Completion write address |
| wr_len | output | 5 | Completion write length in bytes (16 or 4) |
| wr_data | output | 128 | Completion write data |
| wr_ack | input | 1 | Completion write finished in memory |
| tx_valid | output | 1 | Frame beat present |
| tx_ready | input | 1 | Frame beat taken |
| tx_data | output | 64 | Frame bytes |
| tx_keep | output | 8 | Byte-valid mask for the beat |
| tx_last | output | 1 | Final beat of the frame |
| irq | output | 1 | One-cycle interrupt request |
| err | output | 1 | Unsupported descriptor seen |

## Verification
Each kind of internal fault shows up at a particular port:

- A corrupted remaining-byte count shows up in the same frame as a wrong `tx_keep` or a misplaced `tx_last`. It is caught at the latest by the frame's final beat.
- A head register that moves early, or moves with the queue disabled, shows up in the next completion write. That write carries the wrong descriptor address or the wrong index value. It also shows up as an `irq` that does not line up with the head change.
- A lost error flag lets the engine fetch again, so an extra read request appears within a few cycles.

The checks watch those ports at those moments. The bench uses several buffer sizes and alignments and switches the frame back-pressure on and off.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DATA_W     = 64;
  localparam int BEAT_B     = DATA_W / 8;
  localparam int DTYPE_LSB  = 0;
  localparam int DTYPE_W    = 4;
  localparam int EOP_BIT    = 4;
  localparam int SIZE_LSB   = 34;
  localparam int SIZE_W     = 14;
  localparam logic [DTYPE_W-1:0] DTYPE_DATA = 4'h0;
  localparam logic [DTYPE_W-1:0] DTYPE_DONE = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC_RD, ST_BUF_RD, ST_SEND, ST_WB, ST_DONE
  } txr_state_e;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [IDX_W:0]    len_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              hwb_en_in,
  input  logic [ADDR_W-1:0] hwb_addr_in,
  input  logic              tail_we,
  input  logic [IDX_W-1:0]  tail_wd,
  input  logic              advance,
  output logic [IDX_W-1:0]  head,
  output logic [IDX_W-1:0]  next_head,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] hwb_addr,
  output logic              hwb_en,
  output logic              en_rise,
  output logic              has_work
);
  logic             en_d;
  logic [IDX_W-1:0] tail;
  logic [IDX_W:0]   len;
  logic [IDX_W:0]   inc;

  assign en_rise   = enable & ~en_d;
  assign inc       = {1'b0, head} + {{IDX_W{1'b0}}, 1'b1};
  assign next_head = (inc >= len) ? '0 : inc[IDX_W-1:0];
  assign has_work  = enable & en_d & (head != tail);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d     <= 1'b0;
      tail     <= '0;
      head     <= '0;
      len      <= '0;
      base     <= '0;
      hwb_addr <= '0;
      hwb_en   <= 1'b0;
    end else begin
      en_d <= enable;
      if (tail_we) tail <= tail_wd;
      if (en_rise) begin
        head     <= '0;
        len      <= len_in;
        base     <= base_in;
        hwb_en   <= hwb_en_in;
        hwb_addr <= hwb_addr_in;
      end else if (advance) begin
        head <= next_head;
      end
    end
  end
endmodule

// File: rtl/txr_desc_decode.sv
module txr_desc_decode
  import txr_pkg::*;
(
  input  logic [63:0]       ctl_word,
  output logic [SIZE_W-1:0] buf_size,
  output logic              supported
);
  logic [DTYPE_W-1:0] dtype;
  logic               eop;

  assign dtype     = ctl_word[DTYPE_LSB +: DTYPE_W];
  assign eop       = ctl_word[EOP_BIT];
  assign buf_size  = ctl_word[SIZE_LSB +: SIZE_W];
  assign supported = (dtype == DTYPE_DATA) && eop && (buf_size != '0);
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [IDX_W:0]    cfg_ring_len,
  input  logic              cfg_hwb_en,
  input  logic [ADDR_W-1:0] cfg_hwb_addr,
  input  logic              tail_we,
  input  logic [IDX_W-1:0]  tail_wdata,
  output logic [IDX_W-1:0]  head_idx,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [15:0]       rd_req_len,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [4:0]        wr_len,
  output logic [127:0]      wr_data,
  input  logic              wr_ack,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [BEAT_B-1:0] tx_keep,
  output logic              tx_last,
  output logic              irq,
  output logic              err
);
  localparam int SLOT_SHIFT = 4;

  txr_state_e        state;
  logic              req_sent, beat_hi, wr_sent;
  logic [63:0]       w0, w1;
  logic [SIZE_W-1:0] rem, buf_size;
  logic              dec_ok, advance, en_rise, has_work, hwb_en;
  logic [IDX_W-1:0]  next_head;
  logic [ADDR_W-1:0] base, hwb_addr, slot_addr;

  txr_ring_ptr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable),
    .len_in(cfg_ring_len), .base_in(cfg_ring_base),
    .hwb_en_in(cfg_hwb_en), .hwb_addr_in(cfg_hwb_addr),
    .tail_we(tail_we), .tail_wd(tail_wdata), .advance(advance),
    .head(head_idx), .next_head(next_head), .base(base),
    .hwb_addr(hwb_addr), .hwb_en(hwb_en), .en_rise(en_rise),
    .has_work(has_work)
  );

  txr_desc_decode u_dec (
    .ctl_word(w1), .buf_size(buf_size), .supported(dec_ok)
  );

  assign slot_addr = base + (ADDR_W'(head_idx) << SLOT_SHIFT);
  assign advance   = (state == ST_DONE) && cfg_enable;

  // read channel: descriptor fetch, then buffer fetch
  assign rd_req_valid = ((state == ST_DESC_RD) && !req_sent) ||
                        ((state == ST_BUF_RD) && dec_ok);
  assign rd_req_addr  = (state == ST_DESC_RD) ? slot_addr : w0[ADDR_W-1:0];
  assign rd_req_len   = (state == ST_DESC_RD) ? 16'd16 : 16'(buf_size);
  assign rd_rsp_ready = ((state == ST_DESC_RD) && req_sent) ||
                        ((state == ST_SEND) && tx_ready);

  // frame output is a pass-through of the buffer read data
  assign tx_valid = (state == ST_SEND) && rd_rsp_valid;
  assign tx_data  = rd_rsp_data;
  assign tx_last  = rem <= SIZE_W'(BEAT_B);
  for (genvar b = 0; b < BEAT_B; b++) begin : g_keep
    assign tx_keep[b] = rem > SIZE_W'(b);
  end

  // completion write
  assign wr_valid = (state == ST_WB) && !wr_sent;
  assign wr_addr  = hwb_en ? hwb_addr : slot_addr;
  assign wr_len   = hwb_en ? 5'd4 : 5'd16;
  assign wr_data  = hwb_en ? {96'b0, 32'(next_head)}
                           : {64'(DTYPE_DONE), 64'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_sent <= 1'b0;
      beat_hi  <= 1'b0;
      wr_sent  <= 1'b0;
      w0       <= '0;
      w1       <= '0;
      rem      <= '0;
      err      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (en_rise) err <= 1'b0;
      case (state)
        ST_IDLE: if (has_work && !err) begin
          state    <= ST_DESC_RD;
          req_sent <= 1'b0;
          beat_hi  <= 1'b0;
        end
        ST_DESC_RD: begin
          if (rd_req_valid && rd_req_ready) req_sent <= 1'b1;
          if (rd_rsp_valid && rd_rsp_ready) begin
            if (!beat_hi) begin
              w0      <= rd_rsp_data;
              beat_hi <= 1'b1;
            end else begin
              w1    <= rd_rsp_data;
              state <= ST_BUF_RD;
            end
          end
        end
        ST_BUF_RD: begin
          if (!dec_ok) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (rd_req_ready) begin
            rem   <= buf_size;
            state <= ST_SEND;
          end
        end
        ST_SEND: if (tx_valid && tx_ready) begin
          rem <= rem - SIZE_W'(BEAT_B);
          if (tx_last) begin
            state   <= ST_WB;
            wr_sent <= 1'b0;
          end
        end
        ST_WB: begin
          if (wr_valid && wr_ready) wr_sent <= 1'b1;
          if (wr_sent && wr_ack) state <= ST_DONE;
        end
        ST_DONE: begin
          irq   <= cfg_enable;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic [IDX_W-1:0]  head_idx,
  input logic              irq,
  input logic              err,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [127:0]      wr_data,
  input logic              tx_valid
);
  // R2: an offered read request holds until taken
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R7 / R8: an offered completion write holds until taken
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R6: only one channel active per cycle
  a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, wr_valid, tx_valid}));

  // R4: a halted engine stays quiet
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_req_valid && !tx_valid && !wr_valid);

  // R9: interrupt request is a single-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9 / R11: head moves only with an interrupt or right after enable rises
  a_r9_head_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(head_idx) |-> irq || !$past(cfg_enable, 2));

  // R10: no interrupt for a completion seen while disabled
  a_r10_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cfg_enable));
endmodule

bind txring_engine txr_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .head_idx(head_idx),
  .irq(irq), .err(err), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .tx_valid(tx_valid)
);

// File: tb/sim_txring_engine.sv
module sim_txring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int IDX_W  = 8;
  localparam logic [63:0] RING_BASE = 64'h1000;
  localparam logic [63:0] HWB_ADDR  = 64'h8000;

  typedef struct packed { logic bp; logic [13:0] size; logic [31:0] addr; } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b0, 14'd1,  32'h2000}, '{1'b1, 14'd8,  32'h2100},
    '{1'b0, 14'd9,  32'h2203}, '{1'b1, 14'd16, 32'h2300},
    '{1'b1, 14'd61, 32'h2405}, '{1'b0, 14'd24, 32'h2500}};

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_hwb_en = 0, tail_we = 0;
  logic [ADDR_W-1:0] cfg_ring_base = RING_BASE, cfg_hwb_addr = HWB_ADDR;
  logic [IDX_W:0] cfg_ring_len = 6;
  logic [IDX_W-1:0] tail_wdata = 0, head_idx;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0, rd_rsp_ready;
  logic [ADDR_W-1:0] rd_req_addr, wr_addr;
  logic [15:0] rd_req_len;
  logic [63:0] rd_rsp_data = 0, tx_data;
  logic wr_valid, wr_ready = 0, wr_ack = 0, tx_valid, tx_ready = 0, tx_last, irq, err;
  logic [4:0] wr_len;
  logic [127:0] wr_data;
  logic [7:0] tx_keep;

  txring_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] desc_w0 [8], desc_w1 [8];
  logic [63:0] q [64];
  int qh = 0, qt = 0, cyc = 0, ack_cnt = 0, ack_delay = 1;
  bit xfer_pend = 0, bp_en = 0;
  int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0, frames = 0, fr_bytes = 0, fr_len_last = 0, fr_bad = 0;
  logic [63:0] desc_rd_addr = 0, buf_rd_addr = 0, exp_buf = 0, wr_last_addr = 0;
  logic [15:0] desc_rd_len = 0, buf_rd_len = 0;
  logic [4:0]  wr_last_len = 0;
  logic [127:0] wr_last_data = 0;

  function automatic logic [7:0] pat(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [63:0] mk_ctl(input logic [3:0] t, input logic e, input logic [13:0] s);
    return (64'(s) << 34) | (64'(e) << 4) | 64'(t) | 64'h0000_0000_0012_0020;
  endfunction

  // memory model, frame monitor, write acknowledger
  always @(negedge clk) begin
    cyc++;
    if (xfer_pend) qh++;
    tx_ready     = !bp_en || (cyc % 3 != 0);
    rd_req_ready = (cyc % 2 == 1);
    wr_ready     = (cyc % 2 == 0);
    rd_rsp_valid = (qh != qt);
    rd_rsp_data  = q[qh % 64];
    wr_ack = 0;
    if (ack_cnt > 0) begin
      ack_cnt--;
      if (ack_cnt == 0) wr_ack = 1;
    end
    #1;
    xfer_pend = rd_rsp_valid && rd_rsp_ready;
    if (rd_req_valid && rd_req_ready) begin
      rd_cnt++;
      if (rd_req_addr >= RING_BASE && rd_req_addr < RING_BASE + 64'h100) begin
        desc_rd_addr = rd_req_addr; desc_rd_len = rd_req_len;
        q[qt % 64] = desc_w0[(rd_req_addr - RING_BASE) >> 4]; qt++;
        q[qt % 64] = desc_w1[(rd_req_addr - RING_BASE) >> 4]; qt++;
      end else begin
        buf_rd_addr = rd_req_addr; buf_rd_len = rd_req_len;
        for (int j = 0; j < (int'(rd_req_len) + 7) / 8; j++) begin
          logic [63:0] beat;
          for (int b = 0; b < 8; b++) beat[8*b +: 8] = pat(rd_req_addr + 64'(8*j + b));
          q[qt % 64] = beat; qt++;
        end
      end
    end
    if (wr_valid && wr_ready) begin
      wr_cnt++; wr_last_addr = wr_addr; wr_last_len = wr_len; wr_last_data = wr_data;
      ack_cnt = ack_delay;
    end
    if (tx_valid && tx_ready) begin
      if (!tx_last && tx_keep != 8'hFF) fr_bad++;
      for (int b = 0; b < 8; b++) begin
        if (tx_keep[b]) begin
          if (tx_data[8*b +: 8] != pat(exp_buf + 64'(fr_bytes))) fr_bad++;
          fr_bytes++;
        end else if (b == 0 || !tx_keep[b-1] && b < 7 && tx_keep[b+1]) fr_bad++;
      end
      if (tx_last) begin frames++; fr_len_last = fr_bytes; fr_bytes = 0; end
    end
    if (irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_tail(input int v);
    @(negedge clk); tail_we = 1; tail_wdata = IDX_W'(v);
    @(negedge clk); tail_we = 0;
  endtask

  task automatic set_enable(input bit v);
    @(negedge clk); cfg_enable = v;
    @(negedge clk);
  endtask

  task automatic wait_done(input int i0, output bit got);
    got = 0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #2;
      if (irq_cnt > i0) begin got = 1; break; end
      if (err) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    int f0, b0, i0, w0c, r0;
    for (int k = 0; k < 8; k++) begin desc_w0[k] = 0; desc_w1[k] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(head_idx == 0 && !err && !irq, "R1 reset state", head_idx, 0);
    chk(!rd_req_valid && !wr_valid && !tx_valid, "R1 idle channels",
        {rd_req_valid, wr_valid, tx_valid}, 0);

    // R2: tail write while disabled is kept but starts nothing
    desc_w0[0] = 64'(VEC[0].addr); desc_w1[0] = mk_ctl(4'h0, 1'b1, VEC[0].size);
    write_tail(1);
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0, "R2 no fetch while disabled", rd_cnt, 0);

    // table walk, ring of 6 slots, descriptor rewrite completion
    for (int i = 0; i < 6; i++) begin
      desc_w0[i] = 64'(VEC[i].addr); desc_w1[i] = mk_ctl(4'h0, 1'b1, VEC[i].size);
      exp_buf = 64'(VEC[i].addr); bp_en = VEC[i].bp;
      f0 = frames; b0 = fr_bad; i0 = irq_cnt;
      if (i == 0) set_enable(1); else write_tail((i + 1) % 6);
      wait_done(i0, got);
      chk(got && frames == f0 + 1, "R5 frame sent", frames, f0 + 1);
      chk(fr_len_last == int'(VEC[i].size), "R5 frame length", fr_len_last, VEC[i].size);
      chk(fr_bad == b0, "R6 frame bytes/keep under back-pressure", fr_bad, b0);
      chk(desc_rd_addr == RING_BASE + 64'(16 * i) && desc_rd_len == 16, "R2 descriptor read",
          desc_rd_addr, RING_BASE + 64'(16 * i));
      chk(buf_rd_addr == 64'(VEC[i].addr) && buf_rd_len == 16'(VEC[i].size), "R3 buffer read",
          buf_rd_addr, VEC[i].addr);
      chk(wr_last_addr == RING_BASE + 64'(16 * i) && wr_last_len == 16 &&
          wr_last_data == {64'hF, 64'h0}, "R7 descriptor rewrite", wr_last_data[127:64], 64'hF);
      chk(head_idx == IDX_W'((i + 1) % 6), "R9 head after ack", head_idx, (i + 1) % 6);
    end

    // head writeback mode, ring of 4; address change after enable is ignored
    set_enable(0);
    cfg_hwb_en = 1; cfg_ring_len = 4;
    set_enable(1);
    cfg_hwb_addr = 64'h9000;
    bp_en = 0;
    for (int i = 0; i < 4; i++) begin
      desc_w0[i] = 64'h3000 + 64'(64 * i); desc_w1[i] = mk_ctl(4'h0, 1'b1, 14'd12);
      exp_buf = desc_w0[i]; i0 = irq_cnt; w0c = wr_cnt;
      write_tail((i + 1) % 4);
      wait_done(i0, got);
      chk(got && wr_cnt == w0c + 1 && wr_last_len == 4, "R8 head writeback issued", wr_last_len, 4);
      chk(wr_last_addr == HWB_ADDR, "R11 writeback address sampled at enable", wr_last_addr, HWB_ADDR);
      chk(wr_last_data[31:0] == 32'((i + 1) % 4), "R8 writeback value", wr_last_data[31:0], (i + 1) % 4);
      chk(head_idx == IDX_W'((i + 1) % 4), "R9 head wraps", head_idx, (i + 1) % 4);
    end
    cfg_hwb_addr = HWB_ADDR;

    // R4: unsupported descriptors: bad type, no end-of-packet, zero size
    for (int k = 0; k < 3; k++) begin
      set_enable(0);
      cfg_hwb_en = 0;
      desc_w0[0] = 64'h2600;
      desc_w1[0] = (k == 0) ? mk_ctl(4'h1, 1'b1, 14'd8) :
                   (k == 1) ? mk_ctl(4'h0, 1'b0, 14'd8) : mk_ctl(4'h0, 1'b1, 14'd0);
      write_tail(1);
      f0 = frames; w0c = wr_cnt; i0 = irq_cnt;
      set_enable(1);
      wait_done(i0, got);
      chk(err && !got, "R4 error flag set", err, 1);
      chk(frames == f0 && wr_cnt == w0c && head_idx == 0, "R4 no frame/write/head move",
          frames - f0 + wr_cnt - w0c, 0);
      r0 = rd_cnt;
      repeat (20) @(negedge clk);
      chk(rd_cnt == r0, "R4 fetching halted", rd_cnt, r0);
    end
    set_enable(0);
    desc_w1[0] = mk_ctl(4'h0, 1'b1, 14'd8); exp_buf = 64'h2600;
    @(negedge clk); cfg_enable = 1;
    @(negedge clk); #2;
    chk(!err, "R11 enable edge clears error", err, 0);
    i0 = irq_cnt;
    wait_done(i0, got);
    chk(got && head_idx == 1, "R4 recovery after re-enable", head_idx, 1);

    // R10: acknowledgement arrives after the queue is disabled
    desc_w0[1] = 64'h2700; desc_w1[1] = mk_ctl(4'h0, 1'b1, 14'd5); exp_buf = 64'h2700;
    ack_delay = 30; w0c = wr_cnt; i0 = irq_cnt;
    write_tail(2);
    for (int n = 0; n < 500 && wr_cnt == w0c; n++) @(negedge clk);
    cfg_enable = 0;
    repeat (45) @(negedge clk);
    #2;
    chk(irq_cnt == i0 && head_idx == 1, "R10 disabled completion ignored", head_idx, 1);
    ack_delay = 1;
    exp_buf = 64'h2600;
    @(negedge clk); cfg_enable = 1;
    @(negedge clk); #2;
    chk(head_idx == 0, "R11 head reset on enable", head_idx, 0);
    i0 = irq_cnt;
    wait_done(i0, got);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule